// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is locked by watching the two clocks that meet at its phase detector: the divided reference clock and the divided feedback clock. Both are slow compared with a fast sampling clock. The block brings each one into the sampling domain and finds its rising edges. It then pairs each reference edge with the matching feedback edge and measures how many sampling ticks separate them.

A pair is good when the separation is no larger than a programmed window. The lock flag rises once a programmed number of good pairs have arrived in a row. The flag drops at once on any pair outside the window, or on a cycle slip. A cycle slip is a second rising edge of one clock before the other clock has produced any edge.

A feedback-valid input comes from a separate frequency detector. A power-down input, like the valid input, forces the flag low.

Top module: `lockdet_top`

## Requirements
- R1: The separation of a pair is the number of sampling ticks between the first and the second rising edge, counted the same way whichever clock leads. A pair is in-window when this separation is less than or equal to `win_i`. With `win_i` = 0, only edges seen in the same tick qualify.
- R2: `lock_o` rises after exactly `target_i` consecutive in-window pairs and never earlier. It changes within five sampling cycles of the edge that completes a pair.
- R3: A pair whose separation exceeds `win_i` clears `lock_o` and the consecutive count. Regaining lock then takes a full run of `target_i` in-window pairs.
- R4: A cycle slip clears `lock_o` and the count. A slip is two rising edges of one clock with no edge of the other between them. If both clocks rise in the same tick while one clock's edge is already waiting, that also counts as a slip.
- R5: The consecutive count saturates at the target value, so further in-window pairs keep `lock_o` high, even when `target_i` is the largest value the port can hold.
- R6: A `target_i` of 0 behaves as 1.
- R7: The separation counter is WIN_W+1 bits wide and saturates at its top value. A very late second edge is therefore judged a miss, never a wrapped small separation.
- R8: While `fb_valid_i` is low, `lock_o` is low. The internal lock state and count are kept, so lock shows again as soon as `fb_valid_i` returns high.
- R9: While `pwrdn_i` is high, `lock_o` is low and the count, lock state and any pending edge are cleared. After release, a full run of in-window pairs is needed again.
- R10: Synchronous active-low reset `rst_n` clears the lock flag, the count and any pending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_clk_i | input | 1 | Divided reference clock, asynchronous to clk |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous to clk |
| win_i | input | WIN_W | Lock window in sampling ticks |
| target_i | input | CNT_W | Required number of consecutive in-window pairs |
| fb_valid_i | input | 1 | Feedback frequency is valid |
| pwrdn_i | input | 1 | Power-down, active high |
| lock_o | output | 1 | Digital lock flag |

## Verification
Two functions can land in the same sampling tick. The first is pair completion, where the other clock's edge closes a pending pair. The second is slip detection, where the same clock's edge repeats. The bench provokes this by sending a reference edge and then, a few ticks later, both clocks together. The expected result is a dropped flag and a count that restarts from zero, because slip detection has priority over completion.

The main sweep covers every window from 0 to 3, every separation from 0 to 5, both edge orders and targets 1 to 3. For each case the expected flag is computed arithmetically from `separation <= window`, one pair before the target and at the target.

// File: rtl/lockdet_pkg.sv
// Package: shared types for the lock detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lockdet_pkg;

    // Which clock's edge is waiting for its partner.
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_REF  = 2'd1,
        PEND_FB   = 2'd2
    } pend_e;

    // Per-tick outcome reported by the pair timer.
    typedef struct packed {
        logic done;    // a pair completed this tick
        logic in_win;  // the completed pair was inside the window
        logic slip;    // a cycle slip was seen this tick
    } pair_evt_t;

endpackage

// File: rtl/lockdet_edge_sync.sv
// Module: lockdet_edge_sync
// Brings one slow asynchronous clock into the sampling domain through
// STAGES flops and flags its rising edge for one sampling tick.
// Assumes: the input stays high and low for at least two sampling ticks each.
module lockdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] shift_q;

    // Purpose: synchroniser chain plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[LAST-1:0], async_i};
    end

    // Purpose: rising edge = newest synchronised sample high, older low.
    always_comb rise_o = shift_q[LAST-1] & ~shift_q[LAST];

endmodule

// File: rtl/lockdet_pair_timer.sv
// Module: lockdet_pair_timer
// Pairs reference and feedback rising edges, measures their separation in
// sampling ticks from whichever edge arrives first, and reports completion,
// window result and cycle slips one tick later.
// Assumes: edge pulses are single-tick; clr_i acts like a synchronous clear.
module lockdet_pair_timer
    import lockdet_pkg::*;
#(
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ref_rise_i,
    input  logic             fb_rise_i,
    input  logic [WIN_W-1:0] win_i,
    output pair_evt_t        evt_o
);
    localparam int               SEP_W   = WIN_W + 1;
    localparam logic [SEP_W-1:0] SEP_MAX = '1;

    pend_e            pend_q, pend_d;
    logic [SEP_W-1:0] sep_q, sep_d, sep_inc, meas;
    logic [SEP_W-1:0] win_ext;
    pair_evt_t        evt_q, evt_d;

    // Purpose: saturating tick count since the first edge of the pair.
    always_comb begin
        sep_inc = (sep_q == SEP_MAX) ? SEP_MAX : sep_q + 1'b1;
        win_ext = {1'b0, win_i};
    end

    // Purpose: pairing state machine; slip takes priority over completion.
    always_comb begin
        pend_d = pend_q;
        sep_d  = sep_inc;
        meas   = '0;
        evt_d  = '0;
        unique case (pend_q)
            PEND_NONE: begin
                if (ref_rise_i && fb_rise_i) begin
                    evt_d.done = 1'b1;
                    meas       = '0;
                end else if (ref_rise_i) begin
                    pend_d = PEND_REF;
                    sep_d  = '0;
                end else if (fb_rise_i) begin
                    pend_d = PEND_FB;
                    sep_d  = '0;
                end
            end
            PEND_REF: begin
                if (ref_rise_i) begin
                    evt_d.slip = 1'b1;
                    pend_d     = fb_rise_i ? PEND_NONE : PEND_REF;
                    sep_d      = '0;
                end else if (fb_rise_i) begin
                    evt_d.done = 1'b1;
                    meas       = sep_inc;
                    pend_d     = PEND_NONE;
                end
            end
            PEND_FB: begin
                if (fb_rise_i) begin
                    evt_d.slip = 1'b1;
                    pend_d     = ref_rise_i ? PEND_NONE : PEND_FB;
                    sep_d      = '0;
                end else if (ref_rise_i) begin
                    evt_d.done = 1'b1;
                    meas       = sep_inc;
                    pend_d     = PEND_NONE;
                end
            end
            default: pend_d = PEND_NONE;
        endcase
        evt_d.in_win = evt_d.done && (meas <= win_ext);
    end

    // Purpose: state and registered event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pend_q <= PEND_NONE;
            sep_q  <= '0;
            evt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            sep_q  <= sep_d;
            evt_q  <= evt_d;
        end
    end

    always_comb evt_o = evt_q;

endmodule

// File: rtl/lockdet_counter.sv
// Module: lockdet_counter
// Counts consecutive in-window pairs up to the target (saturating) and
// holds the internal lock state; any miss or slip clears both.
// Assumes: events arrive at most once per tick.
module lockdet_counter
    import lockdet_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  pair_evt_t        evt_i,
    input  logic [CNT_W-1:0] target_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] tgt_eff, cnt_q, cnt_d;
    logic             lock_q, lock_d;

    // Purpose: a zero target behaves as one.
    always_comb tgt_eff = (target_i == '0) ? ONE : target_i;

    // Purpose: next count and lock state from this tick's pair event.
    always_comb begin
        cnt_d  = cnt_q;
        lock_d = lock_q;
        if (evt_i.slip || (evt_i.done && !evt_i.in_win)) begin
            cnt_d  = '0;
            lock_d = 1'b0;
        end else if (evt_i.done) begin
            cnt_d  = (cnt_q >= tgt_eff) ? tgt_eff : cnt_q + 1'b1;
            lock_d = (cnt_d >= tgt_eff);
        end
    end

    // Purpose: count and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lock_q <= lock_d;
        end
    end

    always_comb begin
        cnt_o  = cnt_q;
        lock_o = lock_q;
    end

endmodule

// File: rtl/lockdet_top.sv
// Module: lockdet_top
// Digital lock detector: synchronises the two phase-detector clocks,
// times each edge pair and raises lock after a run of in-window pairs.
// Assumes: clk is several times faster than both monitored clocks.
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int WIN_W       = 3,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             fb_clk_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic             fb_valid_i,
    input  logic             pwrdn_i,
    output logic             lock_o
);
    localparam int N_CLK = 2;

    logic [N_CLK-1:0] clk_in, rise;
    pair_evt_t        pr_evt;
    logic             pr_done, pr_in_win, pr_slip;
    logic [CNT_W-1:0] lk_cnt;
    logic             lk_state;

    // Purpose: index 0 is the reference clock, index 1 the feedback clock.
    always_comb clk_in = {fb_clk_i, ref_clk_i};

    for (genvar g = 0; g < N_CLK; g++) begin : g_sync
        lockdet_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (clk_in[g]),
            .rise_o  (rise[g])
        );
    end

    lockdet_pair_timer #(.WIN_W(WIN_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (pwrdn_i),
        .ref_rise_i (rise[0]),
        .fb_rise_i  (rise[1]),
        .win_i      (win_i),
        .evt_o      (pr_evt)
    );

    lockdet_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (pwrdn_i),
        .evt_i    (pr_evt),
        .target_i (target_i),
        .cnt_o    (lk_cnt),
        .lock_o   (lk_state)
    );

    // Purpose: split event fields for observation; gate the flag output.
    always_comb begin
        pr_done   = pr_evt.done;
        pr_in_win = pr_evt.in_win;
        pr_slip   = pr_evt.slip;
        lock_o    = lk_state & fb_valid_i & ~pwrdn_i;
    end

endmodule

// File: rtl/lockdet_chk.sv
// Module: lockdet_chk
// Assertion checker bound to lockdet_top; observes ports and the
// signals passed between the pair timer and the counter.
module lockdet_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwrdn_i,
    input logic             fb_valid_i,
    input logic [CNT_W-1:0] target_i,
    input logic             lock_o,
    input logic             pr_done,
    input logic             pr_in_win,
    input logic             pr_slip,
    input logic             lk_state,
    input logic [CNT_W-1:0] lk_cnt
);
    AST_RISE_AFTER_GOOD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_state) |-> $past(pr_done && pr_in_win)); // R2
    AST_MISS_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_done && !pr_in_win) |=> (!lk_state && lk_cnt == '0)); // R3
    AST_SLIP_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pr_slip |=> (!lk_state && lk_cnt == '0)); // R4
    AST_ONE_EVENT_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pr_done, pr_slip})); // R4
    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (target_i != '0 && $stable(target_i)) |-> (lk_cnt <= target_i)); // R5
    AST_ZERO_TARGET_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (target_i == '0 && pr_done && pr_in_win && !pwrdn_i) |=> lk_state); // R6
    AST_INVALID_FB_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_valid_i |-> !lock_o); // R8
    AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_i |=> (!lk_state && lk_cnt == '0)); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!lk_state && lk_cnt == '0)); // R10
endmodule

bind lockdet_top lockdet_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrdn_i    (pwrdn_i),
    .fb_valid_i (fb_valid_i),
    .target_i   (target_i),
    .lock_o     (lock_o),
    .pr_done    (pr_done),
    .pr_in_win  (pr_in_win),
    .pr_slip    (pr_slip),
    .lk_state   (lk_state),
    .lk_cnt     (lk_cnt)
);

// File: tb/lockdet_top_tb_top.sv
module lockdet_top_tb_top;
    localparam int WIN_W = 3;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_clk = 1'b0, fb_clk = 1'b0;
    logic [WIN_W-1:0] win = '0;
    logic [CNT_W-1:0] target = 4'd1;
    logic             fb_valid = 1'b1, pwrdn = 1'b0;
    logic             lock;
    int               n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    lockdet_top #(.WIN_W(WIN_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
        .win_i(win), .target_i(target), .fb_valid_i(fb_valid),
        .pwrdn_i(pwrdn), .lock_o(lock)
    );

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_clk = 1'b0; fb_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One edge pair: second edge d ticks after first; order chosen by fb_first.
    task automatic send_pair(int d, bit fb_first);
        @(negedge clk);
        if (fb_first) fb_clk = 1'b1; else ref_clk = 1'b1;
        for (int i = 0; i < d; i++) @(negedge clk);
        ref_clk = 1'b1; fb_clk = 1'b1;
        repeat (4) @(negedge clk);
        ref_clk = 1'b0; fb_clk = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic ref_pulse();
        @(negedge clk); ref_clk = 1'b1;
        repeat (4) @(negedge clk); ref_clk = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R10 reset state", lock, 1'b0);

        // R1 R2: sweep window, separation, order and target
        for (int w = 0; w < 4; w++)
            for (int d = 0; d < 6; d++)
                for (int o = 0; o < 2; o++)
                    for (int t = 1; t < 4; t++) begin
                        win = w[WIN_W-1:0]; target = t[CNT_W-1:0];
                        do_reset();
                        for (int k = 0; k < t - 1; k++) send_pair(d, o[0]);
                        check("R2 before target", lock, 1'b0);
                        send_pair(d, o[0]);
                        check("R1 window compare at target", lock, (d <= w));
                    end

        // R3: miss drops lock, count restarts
        win = 3'd2; target = 4'd2; do_reset();
        send_pair(1, 0); send_pair(2, 1);
        check("R3 locked before miss", lock, 1'b1);
        send_pair(3, 0);
        check("R3 miss drops lock", lock, 1'b0);
        send_pair(0, 0);
        check("R3 one pair after miss", lock, 1'b0);
        send_pair(2, 0);
        check("R3 relock after full run", lock, 1'b1);

        // R4: slip by repeated reference edge
        send_pair(0, 0);
        ref_pulse(); ref_pulse();
        check("R4 repeated edge drops lock", lock, 1'b0);

        // R4: coincident edges while a reference edge is pending
        target = 4'd1; do_reset();
        send_pair(0, 0);
        check("R4 locked before coincident slip", lock, 1'b1);
        @(negedge clk); ref_clk = 1'b1;
        repeat (4) @(negedge clk); ref_clk = 1'b0;
        repeat (3) @(negedge clk);
        ref_clk = 1'b1; fb_clk = 1'b1;
        repeat (4) @(negedge clk); ref_clk = 1'b0; fb_clk = 1'b0;
        repeat (10) @(negedge clk);
        check("R4 coincident edges while pending is slip", lock, 1'b0);
        send_pair(0, 0);
        check("R4 relock after slip", lock, 1'b1);

        // R5: saturation at maximum target
        win = 3'd1; target = 4'd15; do_reset();
        for (int k = 0; k < 14; k++) send_pair(1, 0);
        check("R5 one short of max target", lock, 1'b0);
        send_pair(0, 1);
        check("R5 lock at max target", lock, 1'b1);
        for (int k = 0; k < 5; k++) send_pair(1, 1);
        check("R5 saturated count keeps lock", lock, 1'b1);

        // R6: zero target behaves as one
        target = 4'd0; win = 3'd0; do_reset();
        check("R6 no lock before pair", lock, 1'b0);
        send_pair(0, 0);
        check("R6 zero target locks after one pair", lock, 1'b1);

        // R7: very late edge saturates separation and misses at widest window
        win = 3'd7; target = 4'd1; do_reset();
        send_pair(7, 0);
        check("R7 separation at window limit", lock, 1'b1);
        send_pair(20, 1);
        check("R7 saturated separation is miss", lock, 1'b0);

        // R8: invalid feedback masks lock without losing state
        send_pair(3, 0);
        fb_valid = 1'b0; repeat (2) @(negedge clk);
        check("R8 invalid feedback forces low", lock, 1'b0);
        fb_valid = 1'b1; repeat (2) @(negedge clk);
        check("R8 lock restored with valid feedback", lock, 1'b1);

        // R9: power-down forces low and clears state
        target = 4'd2; do_reset();
        send_pair(1, 0); send_pair(1, 0);
        check("R9 locked before power-down", lock, 1'b1);
        pwrdn = 1'b1; repeat (2) @(negedge clk);
        check("R9 power-down forces low", lock, 1'b0);
        pwrdn = 1'b0; repeat (2) @(negedge clk);
        check("R9 stays low after release", lock, 1'b0);
        send_pair(1, 0);
        check("R9 count cleared by power-down", lock, 1'b0);
        send_pair(1, 0);
        check("R9 relock after full run", lock, 1'b1);

        // R10: reset clears lock
        rst_n = 1'b0; repeat (2) @(negedge clk);
        check("R10 reset clears lock", lock, 1'b0);
        rst_n = 1'b1; repeat (2) @(negedge clk);
        check("R10 lock stays low after reset", lock, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule